// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Mailbox

This block gives every CPU in a cluster one mailbox slot for interrupt packets arriving from a system bus. A packet names a target CPU and carries a 5-bit source ID and two 64-bit data words. If the target's slot is free, the block stores the packet and marks the slot busy in the same cycle. It also raises the `accept` signal at once, and one cycle later posts a software-programmed interrupt vector to that CPU. If the slot is still busy, the packet is refused and the sender retries later.

Software sees the slots through a word-addressed register window. The window has indexed views of every CPU's two data words and its busy/source status. It also has three alias words that resolve to the slot of the CPU issuing the access, so a handler can reach its own mailbox without knowing its CPU number. The handler releases its mailbox by writing zero to bit 5 of its busy register. Register reads return data one cycle after the access.

Top module: `cpu_irq_mailbox`

## Requirements
- R1: A packet whose target slot is busy is refused: `pkt_accept` stays low in that cycle, and the slot's busy flag, source and data words are unchanged.
- R2: A packet whose target slot is free is accepted in the same cycle (`pkt_accept` high). At the next clock edge the slot holds busy=1, the packet's source ID and both data words.
- R3: One cycle after an acceptance, `post_valid` is high for one cycle, with `post_cpu` equal to the accepted target and `post_vec` equal to the vector register value in the accepting cycle. `post_valid` is low in every cycle that does not follow an acceptance.
- R4: The shared vector register sits at byte offset 0x318. A write keeps write-data bits 5:0 and drops the rest, and a read returns the 6-bit value zero-extended.
- R5: The status word of CPU i sits at byte offset 0x200 + 8*i. A read returns busy in bit 5 and the source ID in bits 4:0, with all other bits zero.
- R6: A write to a status word loads the busy flag from write-data bit 5 and leaves the stored source ID unchanged.
- R7: Data word 0 of CPU i is at 0x000 + 8*i and data word 1 is at 0x100 + 8*i. Both can be read, and writes to them are ignored.
- R8: The alias offsets 0x300 (data word 0), 0x308 (data word 1) and 0x310 (status) select the slot of `reg_cpu`, for reads and for status writes alike.
- R9: A status write and a packet for the same CPU in the same cycle: the write takes effect first. A write of 0 lets the packet be accepted, and a write of 1 makes it refused.
- R10: `reg_rdata` updates at the clock edge that ends a read and holds until the next read. Reads of unmapped offsets, or of offsets whose bits 2:0 are not zero, return 0.
- R11: After reset all slots are free with zero data and source, the vector is 0, `post_valid` is low and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Interrupt packet present |
| pkt_cpu | input | 5 | Target CPU of the packet |
| pkt_src | input | 5 | Source ID of the packet |
| pkt_d0 | input | 64 | Packet data word 0 |
| pkt_d1 | input | 64 | Packet data word 1 |
| pkt_accept | output | 1 | Packet taken this cycle (low means retry) |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 64 | Write data |
| reg_cpu | input | 5 | ID of the CPU issuing the access |
| reg_rdata | output | 64 | Read data, one cycle after the read |
| post_valid | output | 1 | Interrupt post strobe |
| post_cpu | output | 5 | CPU receiving the post |
| post_vec | output | 6 | Vector being posted |

## Verification
`pkt_accept` is combinational, so the bench drives each stimulus at a falling edge and samples acceptance 1 ns later, before the rising edge. Read data and the post strobe each pass through one register, so both are sampled at the falling edge after the accepting or reading edge, which is exactly one cycle later. Stored slot state becomes visible only through a read issued in a later cycle. For that reason, refusals, ignored writes and same-cycle write-versus-packet ordering are checked by a follow-up read in the next step.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Kind of register addressed by an access, after alias resolution
    typedef enum logic [2:0] {
        REG_NONE = 3'd0,
        REG_D0   = 3'd1,
        REG_D1   = 3'd2,
        REG_STAT = 3'd3,
        REG_VEC  = 3'd4
    } reg_kind_e;

    // Bit of the status word carrying the busy flag
    localparam int STAT_BUSY_BIT = 5;

endpackage

// File: rtl/mbx_regdec.sv
module mbx_regdec
    import mbx_pkg::*;
#(
    parameter int NUM_CPU = 32,
    parameter int ADDR_W  = 12,
    parameter int CPU_W   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CPU_W-1:0]  req_cpu,
    output reg_kind_e         kind,
    output logic [CPU_W-1:0]  idx
);
    localparam int WORD_W    = ADDR_W - 3;
    localparam int BASE_D0   = 0;
    localparam int BASE_D1   = NUM_CPU;
    localparam int BASE_STAT = 2 * NUM_CPU;
    localparam int ALIAS_D0  = 3 * NUM_CPU;
    localparam int ALIAS_D1  = 3 * NUM_CPU + 1;
    localparam int ALIAS_ST  = 3 * NUM_CPU + 2;
    localparam int WORD_VEC  = 3 * NUM_CPU + 3;

    logic [WORD_W-1:0] word;
    int                w;

    assign word = addr[ADDR_W-1:3];

    always_comb begin
        w    = int'(word);
        kind = REG_NONE;
        idx  = '0;
        if (addr[2:0] == 3'b000) begin
            if (w >= BASE_D0 && w < BASE_D1) begin
                kind = REG_D0;
                idx  = CPU_W'(w - BASE_D0);
            end else if (w >= BASE_D1 && w < BASE_STAT) begin
                kind = REG_D1;
                idx  = CPU_W'(w - BASE_D1);
            end else if (w >= BASE_STAT && w < ALIAS_D0) begin
                kind = REG_STAT;
                idx  = CPU_W'(w - BASE_STAT);
            end else if (w == ALIAS_D0) begin
                kind = REG_D0;
                idx  = req_cpu;
            end else if (w == ALIAS_D1) begin
                kind = REG_D1;
                idx  = req_cpu;
            end else if (w == ALIAS_ST) begin
                kind = REG_STAT;
                idx  = req_cpu;
            end else if (w == WORD_VEC) begin
                kind = REG_VEC;
            end
        end
    end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int DATA_W = 64,
    parameter int SRC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic              sw_busy,
    input  logic              load,
    input  logic [SRC_W-1:0]  src_in,
    input  logic [DATA_W-1:0] d0_in,
    input  logic [DATA_W-1:0] d1_in,
    output logic              busy_eff,
    output logic              busy_q,
    output logic [SRC_W-1:0]  src_q,
    output logic [DATA_W-1:0] d0_q,
    output logic [DATA_W-1:0] d1_q
);
    typedef struct packed {
        logic              busy;
        logic [SRC_W-1:0]  src;
        logic [DATA_W-1:0] d0;
        logic [DATA_W-1:0] d1;
    } slot_t;

    slot_t s_d, s_q;

    // Software status write is applied before the packet is judged
    assign busy_eff = sw_we ? sw_busy : s_q.busy;

    always_comb begin
        s_d = s_q;
        if (sw_we) begin
            s_d.busy = sw_busy;
        end
        if (load) begin
            s_d.busy = 1'b1;
            s_d.src  = src_in;
            s_d.d0   = d0_in;
            s_d.d1   = d1_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_q = s_q.busy;
    assign src_q  = s_q.src;
    assign d0_q   = s_q.d0;
    assign d1_q   = s_q.d1;

endmodule

// File: rtl/cpu_irq_mailbox.sv
module cpu_irq_mailbox
    import mbx_pkg::*;
#(
    parameter int NUM_CPU = 32,
    parameter int DATA_W  = 64,
    parameter int SRC_W   = 5,
    parameter int VEC_W   = 6,
    parameter int ADDR_W  = 12,
    parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [CPU_W-1:0]  pkt_cpu,
    input  logic [SRC_W-1:0]  pkt_src,
    input  logic [DATA_W-1:0] pkt_d0,
    input  logic [DATA_W-1:0] pkt_d1,
    output logic              pkt_accept,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CPU_W-1:0]  reg_cpu,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              post_valid,
    output logic [CPU_W-1:0]  post_cpu,
    output logic [VEC_W-1:0]  post_vec
);
    typedef struct packed {
        logic [VEC_W-1:0]  vec;
        logic [DATA_W-1:0] rdata;
        logic              post_valid;
        logic [CPU_W-1:0]  post_cpu;
        logic [VEC_W-1:0]  post_vec;
    } top_t;

    top_t st_d, st_q;

    reg_kind_e         dec_kind;
    logic [CPU_W-1:0]  dec_idx;
    logic              stat_wr;
    logic              pkt_in_range;

    logic [NUM_CPU-1:0] slot_busy_eff;
    logic [NUM_CPU-1:0] slot_busy;
    logic [SRC_W-1:0]   slot_src [NUM_CPU];
    logic [DATA_W-1:0]  slot_d0  [NUM_CPU];
    logic [DATA_W-1:0]  slot_d1  [NUM_CPU];
    logic [VEC_W-1:0]   vec_now;

    mbx_regdec #(
        .NUM_CPU (NUM_CPU),
        .ADDR_W  (ADDR_W),
        .CPU_W   (CPU_W)
    ) u_dec (
        .addr    (reg_addr),
        .req_cpu (reg_cpu),
        .kind    (dec_kind),
        .idx     (dec_idx)
    );

    assign stat_wr      = reg_en && reg_we && (dec_kind == REG_STAT);
    assign pkt_in_range = int'(pkt_cpu) < NUM_CPU;
    assign pkt_accept   = pkt_valid && pkt_in_range && !slot_busy_eff[pkt_cpu];

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_slot
        logic sw_we_i;
        logic load_i;
        assign sw_we_i = stat_wr && (int'(dec_idx) == i);
        assign load_i  = pkt_accept && (int'(pkt_cpu) == i);

        mbx_slot #(
            .DATA_W (DATA_W),
            .SRC_W  (SRC_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .sw_we    (sw_we_i),
            .sw_busy  (reg_wdata[STAT_BUSY_BIT]),
            .load     (load_i),
            .src_in   (pkt_src),
            .d0_in    (pkt_d0),
            .d1_in    (pkt_d1),
            .busy_eff (slot_busy_eff[i]),
            .busy_q   (slot_busy[i]),
            .src_q    (slot_src[i]),
            .d0_q     (slot_d0[i]),
            .d1_q     (slot_d1[i])
        );
    end

    always_comb begin
        st_d            = st_q;
        st_d.post_valid = pkt_accept;
        st_d.post_cpu   = pkt_accept ? pkt_cpu : st_q.post_cpu;
        st_d.post_vec   = pkt_accept ? st_q.vec : st_q.post_vec;

        if (reg_en && reg_we && dec_kind == REG_VEC) begin
            st_d.vec = reg_wdata[VEC_W-1:0];
        end

        if (reg_en && !reg_we) begin
            st_d.rdata = '0;
            unique case (dec_kind)
                REG_D0:   st_d.rdata = slot_d0[dec_idx];
                REG_D1:   st_d.rdata = slot_d1[dec_idx];
                REG_STAT: begin
                    st_d.rdata[SRC_W-1:0]    = slot_src[dec_idx];
                    st_d.rdata[STAT_BUSY_BIT] = slot_busy[dec_idx];
                end
                REG_VEC:  st_d.rdata[VEC_W-1:0] = st_q.vec;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_now    = st_q.vec;
    assign reg_rdata  = st_q.rdata;
    assign post_valid = st_q.post_valid;
    assign post_cpu   = st_q.post_cpu;
    assign post_vec   = st_q.post_vec;

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
    parameter int NUM_CPU = 32,
    parameter int VEC_W   = 6,
    parameter int CPU_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pkt_valid,
    input logic [CPU_W-1:0]   pkt_cpu,
    input logic               pkt_accept,
    input logic [NUM_CPU-1:0] busy_vec,
    input logic [VEC_W-1:0]   vec_now,
    input logic               post_valid,
    input logic [CPU_W-1:0]   post_cpu,
    input logic [VEC_W-1:0]   post_vec
);
    // R2
    accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_accept |-> pkt_valid);

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_accept |=> busy_vec[$past(pkt_cpu)]);

    // R3
    post_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_accept |=> (post_valid && post_cpu == $past(pkt_cpu)));

    // R3
    post_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_accept |=> post_vec == $past(vec_now));

    // R3
    no_spurious_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_accept |=> !post_valid);

endmodule

bind cpu_irq_mailbox mbx_chk #(
    .NUM_CPU (NUM_CPU),
    .VEC_W   (VEC_W),
    .CPU_W   (CPU_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_valid  (pkt_valid),
    .pkt_cpu    (pkt_cpu),
    .pkt_accept (pkt_accept),
    .busy_vec   (slot_busy),
    .vec_now    (vec_now),
    .post_valid (post_valid),
    .post_cpu   (post_cpu),
    .post_vec   (post_vec)
);

// File: tb/cpu_irq_mailbox_tb.sv
`timescale 1ns/1ps
module cpu_irq_mailbox_tb;

    localparam logic [63:0] K  = 64'hFFFF_0000_FFFF_0000;
    localparam logic [63:0] DA = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] DB = 64'hDEAD_BEEF_0000_1111;
    localparam logic [63:0] DC = 64'h5555_AAAA_1234_5678;
    localparam logic [5:0]  VEC = 6'h2A;

    localparam logic [1:0] OP_PKT = 2'd0;
    localparam logic [1:0] OP_WR  = 2'd1;
    localparam logic [1:0] OP_RD  = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  cpu;
        logic [4:0]  src;
        logic [11:0] addr;
        logic [63:0] data;
        logic [63:0] exp;
        logic        acc;
    } step_t;

    localparam int NSTEP = 16;
    localparam step_t TBL [NSTEP] = '{
        '{OP_WR,  5'd0,  5'h00, 12'h318, 64'hFEA,    64'h0,       1'b0}, // R4 write
        '{OP_RD,  5'd0,  5'h00, 12'h318, 64'h0,      64'h2A,      1'b0}, // R4 read
        '{OP_PKT, 5'd3,  5'h11, 12'h000, DA,         64'h0,       1'b1}, // R2
        '{OP_PKT, 5'd3,  5'h05, 12'h000, DB,         64'h0,       1'b0}, // R1
        '{OP_RD,  5'd0,  5'h00, 12'h218, 64'h0,      64'h31,      1'b0}, // R5
        '{OP_RD,  5'd0,  5'h00, 12'h018, 64'h0,      DA,          1'b0}, // R7 R1
        '{OP_RD,  5'd0,  5'h00, 12'h118, 64'h0,      DA ^ K,      1'b0}, // R7
        '{OP_RD,  5'd3,  5'h00, 12'h300, 64'h0,      DA,          1'b0}, // R8
        '{OP_RD,  5'd3,  5'h00, 12'h310, 64'h0,      64'h31,      1'b0}, // R8
        '{OP_WR,  5'd0,  5'h00, 12'h218, 64'h0,      64'h0,       1'b0}, // R6
        '{OP_RD,  5'd0,  5'h00, 12'h218, 64'h0,      64'h11,      1'b0}, // R6
        '{OP_PKT, 5'd3,  5'h07, 12'h000, DB,         64'h0,       1'b1}, // R2
        '{OP_RD,  5'd0,  5'h00, 12'h018, 64'h0,      DB,          1'b0}, // R2
        '{OP_PKT, 5'd31, 5'h1F, 12'h000, DC,         64'h0,       1'b1}, // R2
        '{OP_RD,  5'd31, 5'h00, 12'h308, 64'h0,      DC ^ K,      1'b0}, // R8
        '{OP_RD,  5'd0,  5'h00, 12'h2F8, 64'h0,      64'h3F,      1'b0}  // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [4:0]  pkt_cpu = '0;
    logic [4:0]  pkt_src = '0;
    logic [63:0] pkt_d0 = '0;
    logic [63:0] pkt_d1 = '0;
    logic        pkt_accept;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [4:0]  reg_cpu = '0;
    logic [63:0] reg_rdata;
    logic        post_valid;
    logic [4:0]  post_cpu;
    logic [5:0]  post_vec;

    int errors = 0;
    int checks = 0;
    logic got_acc;
    logic done = 1'b0;

    always #10 clk = ~clk;

    cpu_irq_mailbox u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_valid  (pkt_valid),
        .pkt_cpu    (pkt_cpu),
        .pkt_src    (pkt_src),
        .pkt_d0     (pkt_d0),
        .pkt_d1     (pkt_d1),
        .pkt_accept (pkt_accept),
        .reg_en     (reg_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_cpu    (reg_cpu),
        .reg_rdata  (reg_rdata),
        .post_valid (post_valid),
        .post_cpu   (post_cpu),
        .post_vec   (post_vec)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drives one cycle from a falling edge; ends at the next falling edge
    task automatic cyc(input logic pv, input logic [4:0] pc, input logic [4:0] ps,
                       input logic [63:0] pd, input logic re, input logic rw,
                       input logic [11:0] ra, input logic [63:0] rd, input logic [4:0] rc);
        pkt_valid = pv; pkt_cpu = pc; pkt_src = ps; pkt_d0 = pd; pkt_d1 = pd ^ K;
        reg_en = re; reg_we = rw; reg_addr = ra; reg_wdata = rd; reg_cpu = rc;
        #1 got_acc = pkt_accept;
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [4:0] c);
        cyc(1'b0, 5'd0, 5'd0, 64'h0, 1'b1, 1'b0, a, 64'h0, c);
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [4:0] c);
        cyc(1'b0, 5'd0, 5'd0, 64'h0, 1'b1, 1'b1, a, d, c);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 post_valid", {63'b0, post_valid}, 64'h0);
        chk("R11 rdata", reg_rdata, 64'h0);
        rd(12'h318, 5'd0); chk("R11 vector", reg_rdata, 64'h0);
        rd(12'h200, 5'd0); chk("R11 status", reg_rdata, 64'h0);
        rd(12'h1F8, 5'd0); chk("R11 data1", reg_rdata, 64'h0);

        for (int i = 0; i < NSTEP; i++) begin
            step_t s;
            s = TBL[i];
            case (s.op)
                OP_PKT: begin
                    cyc(1'b1, s.cpu, s.src, s.data, 1'b0, 1'b0, 12'h0, 64'h0, 5'd0);
                    chk(s.acc ? "R2 accept" : "R1 refuse", {63'b0, got_acc}, {63'b0, s.acc});
                    chk("R3 post_valid", {63'b0, post_valid}, {63'b0, s.acc});
                    if (s.acc) begin
                        chk("R3 post_cpu", {59'b0, post_cpu}, {59'b0, s.cpu});
                        chk("R3 post_vec", {58'b0, post_vec}, {58'b0, VEC});
                    end
                end
                OP_WR: wr(s.addr, s.data, s.cpu);
                default: begin
                    rd(s.addr, s.cpu);
                    chk("R4 R5 R6 R7 R8 table read", reg_rdata, s.exp);
                end
            endcase
        end

        // R9 clear-by-write and packet together: packet wins the free slot
        cyc(1'b1, 5'd3, 5'h02, DA, 1'b1, 1'b1, 12'h218, 64'h0, 5'd0);
        chk("R9 clear then accept", {63'b0, got_acc}, 64'h1);
        rd(12'h218, 5'd0); chk("R9 status after", reg_rdata, 64'h22);

        // R9 set-by-write and packet together: packet refused
        cyc(1'b1, 5'd5, 5'h09, DB, 1'b1, 1'b1, 12'h228, 64'h20, 5'd0);
        chk("R9 set then refuse", {63'b0, got_acc}, 64'h0);
        chk("R3 no post on refuse", {63'b0, post_valid}, 64'h0);
        rd(12'h228, 5'd0); chk("R9 status cpu5", reg_rdata, 64'h20);
        rd(12'h028, 5'd0); chk("R1 data untouched cpu5", reg_rdata, 64'h0);

        // R8 alias status write releases requester's own slot
        wr(12'h310, 64'h0, 5'd31);
        rd(12'h2F8, 5'd0); chk("R8 alias release", reg_rdata, 64'h1F);

        // R7 data writes ignored
        wr(12'h018, 64'hFFFF, 5'd0);
        rd(12'h018, 5'd0); chk("R7 write ignored", reg_rdata, DA);

        // R10 hold and unmapped
        rd(12'h318, 5'd0);
        cyc(1'b0, 5'd0, 5'd0, 64'h0, 1'b0, 1'b0, 12'h0, 64'h0, 5'd0);
        chk("R10 hold", reg_rdata, 64'h2A);
        rd(12'h400, 5'd0); chk("R10 unmapped", reg_rdata, 64'h0);
        rd(12'h31C, 5'd0); chk("R10 misaligned", reg_rdata, 64'h0);

        finish_run();
    end

endmodule